// File: doc/BRIEF.md
# Serial Control Port Slave

This block is the configuration front end of an audio converter. A host microcontroller writes to it over three plain wires: a control clock, a serial data line and a mode line. The block brings the three wires into the system clock domain, gathers the data line into bytes, and uses each complete byte to update a small set of registered settings. The settings are the oversampling clock ratio, the serial input format, the volume attenuation, the de-emphasis choice and the soft-mute flag. The audio path reads these settings, and they stay steady between writes.

A write has two kinds of byte, and the mode line tells them apart. A byte sent with the mode line low is an address byte. It carries a six-bit device identity and a two-bit bank choice. A byte sent with the mode line high is a data byte for the chosen bank. The chosen bank stays in force for any number of following data bytes, until the host sends another address byte. The port only receives. Nothing can be read back from it. It has no stream interface, so there is no back-pressure, and all of its pins are plain level signals.

Top module: `cfg_ctrl_slave`

## Requirements
- R1: After reset the outputs are: volume 0, de-emphasis 00, mute 0, format 000 and clock ratio 10. The port starts deselected, so data bytes sent before any address byte change nothing.
- R2: Bits arrive least significant first, and the eighth bit completes a byte. A byte takes effect only when it is complete. Any change of the mode line clears the bit count, so a partial byte is discarded.
- R3: A byte sent with the mode line low is an address byte. It selects the port only when bits 7..2 equal 000101. Any other identity deselects the port, and the data bytes that follow are then ignored until a matching address byte arrives. Address bytes never change the settings themselves.
- R4: Address bits 1..0 pick the bank: 00 is the data bank and 10 is the status bank. With 01 or 11, the data bytes that follow change no setting.
- R5: After one address byte, several data bytes in a row each take effect on the same bank.
- R6: In the status bank, a byte with bit 7 = 0 loads the clock ratio from bits 5..4 and the format from bits 3..1. A status byte with bit 7 = 1 changes nothing.
- R7: Clock ratio codes are 00 = 512x, 01 = 384x and 10 = 256x. The code 11 leaves the clock ratio unchanged, and the output never shows 11.
- R8: Format codes are 000 = I2S, 001/010/011 = LSB-justified 16/18/20 bits and 100 = MSB-justified. The codes 101 to 111 leave the format unchanged.
- R9: In the data bank, a byte with bits 7..6 = 00 loads the volume from bits 5..0. Code 0 is 0 dB, and each step adds 1 dB of attenuation.
- R10: In the data bank, a byte with bits 7..6 = 10 loads de-emphasis from bits 4..3 and mute from bit 2. The de-emphasis codes are 00 = off, 01 = 32 kHz, 10 = 44.1 kHz and 11 = 48 kHz.
- R11: In the data bank, a byte with bits 7..6 = 11 and bits 5..0 = 000001 returns volume, de-emphasis and mute to their reset values. Any other value under 11, and every byte under 01, has no effect.
- R12: Each control line passes through a two-flop synchroniser. A bit is taken on a detected rising edge of the control clock. The settings update four system clock cycles after the rising control clock edge that ends a byte is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_clk_i | input | 1 | Control clock from the host, asynchronous |
| ctl_dat_i | input | 1 | Serial control data, least significant bit first |
| ctl_mode_i | input | 1 | Low = address byte, high = data byte |
| clk_ratio_o | output | 2 | Oversampling clock ratio code |
| fmt_o | output | 3 | Serial audio input format code |
| vol_o | output | 6 | Volume attenuation in 1 dB steps |
| deemph_o | output | 2 | De-emphasis selection |
| mute_o | output | 1 | Soft mute enable |

## Verification
The hardest case to reach is a partial byte left behind by a mode change. If the bit count were not cleared, the stray bits would misalign every later byte. The stimulus clocks in five bits of a data byte and then checks that nothing has changed. It then drops the mode line and sends a full address byte and a new data byte. The new volume appears only if the leftover bits were thrown away. A separate test presents the final control clock edge by hand and samples both before and after the fourth system cycle, which pins down the synchroniser latency.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam int BYTE_W   = 8;
  localparam int ID_W     = 6;
  localparam int VOL_W    = 6;
  localparam int FMT_W    = 3;
  localparam int RATIO_W  = 2;
  localparam int DEEM_W   = 2;

  typedef enum logic [1:0] {
    BANK_DATA = 2'b00,
    BANK_RSVA = 2'b01,
    BANK_STAT = 2'b10,
    BANK_RSVB = 2'b11
  } bank_e;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic [FMT_W-1:0]   fmt;
    logic [VOL_W-1:0]   vol;
    logic [DEEM_W-1:0]  deem;
    logic               mute;
  } cfg_t;

  localparam logic [RATIO_W-1:0] RATIO_RSVD = 2'b11;
  localparam logic [FMT_W-1:0]   FMT_MAX    = 3'b100;

  localparam cfg_t CFG_RESET = '{
    ratio: 2'b10,
    fmt:   3'b000,
    vol:   6'd0,
    deem:  2'b00,
    mute:  1'b0
  };

endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/cfg_byte_rx.sv
module cfg_byte_rx
  import cfg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_clk,
  input  logic              s_dat,
  input  logic              s_mode,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q,
  output logic              byte_mode
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              clk_q;
  logic              mode_q;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              rise;
  logic              mode_chg;
  logic [BYTE_W-1:0] shnext;

  assign rise     = s_clk & ~clk_q;
  assign mode_chg = s_mode ^ mode_q;
  assign shnext   = {s_dat, shreg[BYTE_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q     <= 1'b0;
      mode_q    <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      byte_vld  <= 1'b0;
      byte_q    <= '0;
      byte_mode <= 1'b0;
    end else begin
      clk_q    <= s_clk;
      mode_q   <= s_mode;
      byte_vld <= 1'b0;
      if (mode_chg) begin
        cnt <= '0;
      end else if (rise) begin
        shreg <= shnext;
        if (cnt == LAST) begin
          cnt       <= '0;
          byte_vld  <= 1'b1;
          byte_q    <= shnext;
          byte_mode <= s_mode;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld); // R2

  AST_MODE_CHG_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !byte_vld); // R2

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_port_pkg::*;
#(
  parameter logic [ID_W-1:0] DEV_ID = 6'b000101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_q,
  input  logic              byte_mode,
  output cfg_t              cfg
);

  logic  sel;
  bank_e bank;
  cfg_t  cfg_nxt;
  logic  wr_data;

  assign wr_data = byte_vld & byte_mode & sel;

  always_comb begin
    cfg_nxt = cfg;
    if (wr_data) begin
      unique case (bank)
        BANK_STAT: begin
          if (!byte_q[7]) begin
            if (byte_q[5:4] != RATIO_RSVD) cfg_nxt.ratio = byte_q[5:4];
            if (byte_q[3:1] <= FMT_MAX)    cfg_nxt.fmt   = byte_q[3:1];
          end
        end
        BANK_DATA: begin
          unique case (byte_q[7:6])
            2'b00: cfg_nxt.vol = byte_q[5:0];
            2'b10: begin
              cfg_nxt.deem = byte_q[4:3];
              cfg_nxt.mute = byte_q[2];
            end
            2'b11: begin
              if (byte_q[5:0] == 6'd1) begin
                cfg_nxt.vol  = CFG_RESET.vol;
                cfg_nxt.deem = CFG_RESET.deem;
                cfg_nxt.mute = CFG_RESET.mute;
              end
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= 1'b0;
      bank <= BANK_DATA;
      cfg  <= CFG_RESET;
    end else begin
      cfg <= cfg_nxt;
      if (byte_vld && !byte_mode) begin
        sel  <= (byte_q[7:2] == DEV_ID);
        bank <= bank_e'(byte_q[1:0]);
      end
    end
  end

  AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.ratio != RATIO_RSVD); // R7

  AST_HOLD_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(cfg)); // R2

  AST_ADDR_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !byte_mode) |=> $stable(cfg)); // R3

  AST_DESEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_mode && !sel) |=> $stable(cfg)); // R3

  AST_RSV_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_mode && bank[0]) |=> $stable(cfg)); // R4

  AST_STAT_HI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_mode && bank == BANK_STAT && byte_q[7]) |=> $stable(cfg)); // R6

endmodule

// File: rtl/cfg_ctrl_slave.sv
module cfg_ctrl_slave
  import cfg_port_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [ID_W-1:0]  DEV_ID      = 6'b000101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_clk_i,
  input  logic               ctl_dat_i,
  input  logic               ctl_mode_i,
  output logic [RATIO_W-1:0] clk_ratio_o,
  output logic [FMT_W-1:0]   fmt_o,
  output logic [VOL_W-1:0]   vol_o,
  output logic [DEEM_W-1:0]  deemph_o,
  output logic               mute_o
);

  localparam int NLINES = 3;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] syn_lines;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_q;
  logic              byte_mode;
  cfg_t              cfg;

  assign raw_lines = {ctl_mode_i, ctl_dat_i, ctl_clk_i};

  cfg_line_sync #(.STAGES(SYNC_STAGES), .LINES(NLINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_lines),
    .dout (syn_lines)
  );

  cfg_byte_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_clk    (syn_lines[0]),
    .s_dat    (syn_lines[1]),
    .s_mode   (syn_lines[2]),
    .byte_vld (byte_vld),
    .byte_q   (byte_q),
    .byte_mode(byte_mode)
  );

  cfg_regs #(.DEV_ID(DEV_ID)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_vld (byte_vld),
    .byte_q   (byte_q),
    .byte_mode(byte_mode),
    .cfg      (cfg)
  );

  assign clk_ratio_o = cfg.ratio;
  assign fmt_o       = cfg.fmt;
  assign vol_o       = cfg.vol;
  assign deemph_o    = cfg.deem;
  assign mute_o      = cfg.mute;

endmodule

// File: tb/cfg_ctrl_slave_test.sv
module cfg_ctrl_slave_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_clk = 1'b0;
  logic       ctl_dat = 1'b0;
  logic       ctl_mode = 1'b0;
  logic [1:0] clk_ratio;
  logic [2:0] fmt;
  logic [5:0] vol;
  logic [1:0] deemph;
  logic       mute;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_ctrl_slave uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_clk_i  (ctl_clk),
    .ctl_dat_i  (ctl_dat),
    .ctl_mode_i (ctl_mode),
    .clk_ratio_o(clk_ratio),
    .fmt_o      (fmt),
    .vol_o      (vol),
    .deemph_o   (deemph),
    .mute_o     (mute)
  );

  // Vector layout: addr[29:22] data[21:14] then expected {ratio,fmt,vol,deem,mute}
  localparam int NV = 12;
  localparam logic [29:0] VEC [NV] = '{
    {8'h14, 8'h2A, 2'b10, 3'b000, 6'd42, 2'b00, 1'b0},  // R9 volume load
    {8'h14, 8'h9C, 2'b10, 3'b000, 6'd42, 2'b11, 1'b1},  // R10 de-emphasis and mute
    {8'h16, 8'h16, 2'b01, 3'b011, 6'd42, 2'b11, 1'b1},  // R6 status load
    {8'h16, 8'h38, 2'b01, 3'b100, 6'd42, 2'b11, 1'b1},  // R7 ratio 11 kept out
    {8'h16, 8'h0A, 2'b00, 3'b100, 6'd42, 2'b11, 1'b1},  // R8 format 101 kept out
    {8'h16, 8'hA4, 2'b00, 3'b100, 6'd42, 2'b11, 1'b1},  // R6 bit7 set ignored
    {8'h15, 8'h05, 2'b00, 3'b100, 6'd42, 2'b11, 1'b1},  // R4 bank 01
    {8'h17, 8'h00, 2'b00, 3'b100, 6'd42, 2'b11, 1'b1},  // R4 bank 11
    {8'h24, 8'h11, 2'b00, 3'b100, 6'd42, 2'b11, 1'b1},  // R3 foreign id
    {8'h14, 8'h7F, 2'b00, 3'b100, 6'd42, 2'b11, 1'b1},  // R11 sub-register 01
    {8'h14, 8'hC2, 2'b00, 3'b100, 6'd42, 2'b11, 1'b1},  // R11 11 with other value
    {8'h14, 8'hC1, 2'b00, 3'b100, 6'd0,  2'b00, 1'b0}   // R11 restore
  };
  localparam int VTAG [NV] = '{9, 10, 6, 7, 8, 6, 4, 4, 3, 11, 11, 11};

  function automatic logic [13:0] outs();
    return {clk_ratio, fmt, vol, deemph, mute};
  endfunction

  task automatic check(input string tag, input logic [13:0] got, input logic [13:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    ctl_mode = m;
    repeat (4) @(negedge clk);
  endtask

  task automatic clk_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      ctl_dat = b[i];
      repeat (4) @(negedge clk);
      ctl_clk = 1'b1;
      repeat (4) @(negedge clk);
      ctl_clk = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset values
    check("R1 reset", outs(), {2'b10, 3'b000, 6'd0, 2'b00, 1'b0});

    // R1 deselected after reset: data byte without address
    set_mode(1'b1);
    clk_bits(8'h15, 8);
    settle();
    check("R1 deselected", outs(), {2'b10, 3'b000, 6'd0, 2'b00, 1'b0});

    for (int v = 0; v < NV; v++) begin
      set_mode(1'b0);
      clk_bits(VEC[v][29:22], 8);
      set_mode(1'b1);
      clk_bits(VEC[v][21:14], 8);
      settle();
      check($sformatf("R%0d vector %0d", VTAG[v], v), outs(), VEC[v][13:0]);
    end

    // R5: several data bytes after one address
    set_mode(1'b0);
    clk_bits(8'h14, 8);
    set_mode(1'b1);
    clk_bits(8'h05, 8);
    settle();
    check("R5 first byte", outs(), {2'b00, 3'b100, 6'd5, 2'b00, 1'b0});
    clk_bits(8'h88, 8);
    settle();
    check("R5 second byte", outs(), {2'b00, 3'b100, 6'd5, 2'b01, 1'b0});
    clk_bits(8'h07, 8);
    settle();
    check("R5 third byte", outs(), {2'b00, 3'b100, 6'd7, 2'b01, 1'b0});

    // R2: partial byte has no effect and is dropped on mode change
    clk_bits(8'h3F, 5);
    settle();
    check("R2 partial held", outs(), {2'b00, 3'b100, 6'd7, 2'b01, 1'b0});
    set_mode(1'b0);
    clk_bits(8'h14, 8);
    set_mode(1'b1);
    clk_bits(8'h09, 8);
    settle();
    check("R2 realigned", outs(), {2'b00, 3'b100, 6'd9, 2'b01, 1'b0});

    // R12: update latency after the final rising control clock edge
    clk_bits(8'h21, 7);
    ctl_dat = 1'b0;
    repeat (4) @(negedge clk);
    ctl_clk = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    check("R12 before update", outs(), {2'b00, 3'b100, 6'd9, 2'b01, 1'b0});
    @(posedge clk);
    @(posedge clk);
    #1;
    check("R12 after update", outs(), {2'b00, 3'b100, 6'd33, 2'b01, 1'b0});
    @(negedge clk);
    ctl_clk = 1'b0;
    settle();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule